// File: doc/BRIEF.md
# Half-Bridge Dead-Band Generator

This block turns one or two raw PWM waveforms into the high-side and low-side drive pins of a half-bridge. In independent mode each pin simply follows its own raw waveform one clock later. In complementary mode a select input picks one raw waveform as the source. The high-side pin is active while that source is high and the low-side pin is active while it is low. After every change of the source, both pins are held inactive for a programmable number of clock cycles. This gap gives the power switch that is turning off time to do so before the other switch turns on.

The gap before the high-side pin turns on and the gap before the low-side pin turns on are programmed separately. This suits switches whose turn-off times differ. A polarity bit per pin is applied last, so each pin can be active-high or active-low. The PWM counter, fault shutdown and software forcing of the pins sit outside this block.

Top module: `halfbridge_deadband`

## Requirements
- R1: With `split_mode`=1, `hs_pin` and `ls_pin` show `wave_a` and `wave_b` respectively, as sampled at the previous rising clock edge, with no gap inserted. This means both pins may be active at once.
- R2: With `split_mode`=0, `src_pick`=0 selects `wave_a` as the pair source and `src_pick`=1 selects `wave_b`. The other raw wave has no effect. A source of 1 asks for the high-side pin, a source of 0 asks for the low-side pin, and a change of `src_pick` that changes the source counts as a source transition.
- R3: In complementary mode, when the source rises and `gap_hs`=N, both pins are inactive for N samples taken at falling edges. The high-side pin becomes active at the (N+1)-th falling edge after the rising edge that first saw the new source value.
- R4: In complementary mode, when the source falls and `gap_ls`=N, both pins are inactive for N samples. The low-side pin becomes active at the (N+1)-th falling edge after the rising edge that first saw the new source value.
- R5: With a gap count of 0, the pins are purely complementary: the pin being turned on becomes active in the same cycle that the other pin becomes inactive, one clock after the source change.
- R6: If the source changes again before a gap expires, the gap restarts with the count for the new direction, and neither pin becomes active until that full new gap has elapsed.
- R7: In complementary mode both pins are never active in the same cycle.
- R8: Each pin equals its internal active state XOR its polarity bit (`inv_hs`, `inv_ls`). A polarity bit of 1 makes the pin active-low. A polarity change shows on the pin without waiting for a clock edge.
- R9: During synchronous reset (`rst_n`=0 at a rising edge), both internal active states are cleared, so each pin shows its polarity bit, which is its inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; gap counts are in cycles of this clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_a | input | 1 | First raw PWM waveform |
| wave_b | input | 1 | Second raw PWM waveform |
| split_mode | input | 1 | 1: independent channels, 0: complementary pair |
| src_pick | input | 1 | Complementary source: 0 wave_a, 1 wave_b |
| gap_hs | input | CNT_W | Gap in cycles before the high-side pin turns on |
| gap_ls | input | CNT_W | Gap in cycles before the low-side pin turns on |
| inv_hs | input | 1 | High-side polarity, 1 = active-low |
| inv_ls | input | 1 | Low-side polarity, 1 = active-low |
| hs_pin | output | 1 | High-side drive pin |
| ls_pin | output | 1 | Low-side drive pin |

## Verification
Every independent-mode combination of the two raw waves is applied, including both high at once; this separates a correct pass-through from a design that wrongly keeps dead-band interlocking active. Isolated rising and falling source edges, with unequal counts for the two directions, measure each gap exactly and would expose swapped counts or an off-by-one. A reversal in the middle of a gap, and a source switch made only through the select input, show whether the gap restarts with the count for the new direction. A long randomized run then mixes modes, gap counts and polarity against a cycle-level model to catch any cycle with both pins active.

// File: rtl/dtp_pkg.sv
// Shared types for the half-bridge dead-band generator.
// Assumes: bit 1 of a pair is the high side, bit 0 the low side.
package dtp_pkg;
    // Active-state pair for the two drive pins, high side in the MSB
    typedef struct packed {
        logic hs;
        logic ls;
    } drive_pair_t;

    localparam int PAIR_WIDTH = 2;
endpackage

// File: rtl/dtp_source_sel.sv
// Source selector: picks which raw wave feeds the complementary pair.
// Assumes: both raw waves are already synchronous to clk.
module dtp_source_sel (
    input  logic pick,
    input  logic wave_a,
    input  logic wave_b,
    output logic src
);
    // Choose the pair source from the select bit
    always_comb begin
        src = pick ? wave_b : wave_a;
    end
endmodule

// File: rtl/dtp_gap_timer.sv
// Gap timer: remembers the settled source level and counts down the
// dead band after every source transition. Its outputs are the active
// states requested for the next cycle.
// Assumes: gap counts are sampled in the cycle the transition is seen.
module dtp_gap_timer
    import dtp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             src,
    input  logic [CNT_W-1:0] gap_hs,
    input  logic [CNT_W-1:0] gap_ls,
    output drive_pair_t      want
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic             level_q, level_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             settled;

    // Next-state: reload on a transition, otherwise count down to zero
    always_comb begin
        level_d = level_q;
        left_d  = left_q;
        if (bypass) begin
            level_d = src;
            left_d  = CNT_ZERO;
        end else if (src != level_q) begin
            level_d = src;
            left_d  = src ? gap_hs : gap_ls;
        end else if (left_q != CNT_ZERO) begin
            left_d = left_q - CNT_ONE;
        end
    end

    // Requested active states: only once the gap has fully run out
    always_comb begin
        settled = (left_d == CNT_ZERO);
        want.hs = level_d & settled;
        want.ls = ~level_d & settled;
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            left_q  <= CNT_ZERO;
        end else begin
            level_q <= level_d;
            left_q  <= left_d;
        end
    end
endmodule

// File: rtl/dtp_drive_stage.sv
// Drive stage: registers the active states (independent or gated) and
// applies per-pin polarity after the register.
// Assumes: polarity bits are static configuration or may change freely.
module dtp_drive_stage
    import dtp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  split,
    input  drive_pair_t           raw,
    input  drive_pair_t           gated,
    input  logic [PAIR_WIDTH-1:0] invert,
    output logic [PAIR_WIDTH-1:0] pins
);
    drive_pair_t             act_q, act_d;
    logic [PAIR_WIDTH-1:0]   act_vec;

    // Pick raw waves in independent mode, gated pair otherwise
    always_comb begin
        act_d = split ? raw : gated;
    end

    // Active-state register, cleared to inactive in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_vec = act_q;

    // Per-pin polarity applied after the register
    for (genvar i = 0; i < PAIR_WIDTH; i++) begin : g_pol
        assign pins[i] = act_vec[i] ^ invert[i];
    end
endmodule

// File: rtl/halfbridge_deadband.sv
// Half-bridge dead-band generator top level. Selects the source, runs
// the gap timer and drives the two polarity-adjusted pins.
// Assumes: all inputs are synchronous to clk.
module halfbridge_deadband
    import dtp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wave_a,
    input  logic             wave_b,
    input  logic             split_mode,
    input  logic             src_pick,
    input  logic [CNT_W-1:0] gap_hs,
    input  logic [CNT_W-1:0] gap_ls,
    input  logic             inv_hs,
    input  logic             inv_ls,
    output logic             hs_pin,
    output logic             ls_pin
);
    logic                  pair_src;
    drive_pair_t           gated;
    drive_pair_t           raw;
    logic [PAIR_WIDTH-1:0] pins;

    dtp_source_sel u_sel (
        .pick   (src_pick),
        .wave_a (wave_a),
        .wave_b (wave_b),
        .src    (pair_src)
    );

    dtp_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .bypass (split_mode),
        .src    (pair_src),
        .gap_hs (gap_hs),
        .gap_ls (gap_ls),
        .want   (gated)
    );

    // Raw pair for independent mode
    always_comb begin
        raw.hs = wave_a;
        raw.ls = wave_b;
    end

    dtp_drive_stage u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .split  (split_mode),
        .raw    (raw),
        .gated  (gated),
        .invert ({inv_hs, inv_ls}),
        .pins   (pins)
    );

    assign hs_pin = pins[1];
    assign ls_pin = pins[0];
endmodule

// File: rtl/halfbridge_deadband_sva.sv
// Property checker for the half-bridge dead-band generator, bound to
// the top. Active states are recovered from pins and polarity.
module halfbridge_deadband_sva #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wave_a,
    input logic             wave_b,
    input logic             split_mode,
    input logic [CNT_W-1:0] gap_hs,
    input logic [CNT_W-1:0] gap_ls,
    input logic             inv_hs,
    input logic             inv_ls,
    input logic             hs_pin,
    input logic             ls_pin
);
    logic hs_on, ls_on;
    assign hs_on = hs_pin ^ inv_hs;
    assign ls_on = ls_pin ^ inv_ls;

    AST_SPLIT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(split_mode) |-> (hs_on == $past(wave_a)) && (ls_on == $past(wave_b))); // R1

    AST_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_on) && !$past(split_mode) && !$past(split_mode, 2) && ($past(gap_hs) != '0))
        |-> !$past(ls_on)); // R3

    AST_LS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_on) && !$past(split_mode) && !$past(split_mode, 2) && ($past(gap_ls) != '0))
        |-> !$past(hs_on)); // R4

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(split_mode) && !$past(split_mode, 2)) |-> !(hs_on && ls_on)); // R7

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!hs_on && !ls_on)); // R9
endmodule

bind halfbridge_deadband halfbridge_deadband_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wave_a     (wave_a),
    .wave_b     (wave_b),
    .split_mode (split_mode),
    .gap_hs     (gap_hs),
    .gap_ls     (gap_ls),
    .inv_hs     (inv_hs),
    .inv_ls     (inv_ls),
    .hs_pin     (hs_pin),
    .ls_pin     (ls_pin)
);

// File: tb/halfbridge_deadband_test.sv
// Bench: behavioural cycle model compared at every falling edge, plus
// directed measurements of each gap.
module halfbridge_deadband_test;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wave_a = 1'b0, wave_b = 1'b0, split_mode = 1'b0, src_pick = 1'b0;
    logic [CW-1:0] gap_hs = '0, gap_ls = '0;
    logic inv_hs = 1'b0, inv_ls = 1'b0;
    logic hs_pin, ls_pin;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R9";
    bit model_live = 1'b0;

    // behavioural model state
    bit m_level = 1'b0;
    int m_left = 0;
    bit m_hs = 1'b0, m_ls = 1'b0;

    halfbridge_deadband #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wave_a(wave_a), .wave_b(wave_b),
        .split_mode(split_mode), .src_pick(src_pick),
        .gap_hs(gap_hs), .gap_ls(gap_ls), .inv_hs(inv_hs), .inv_ls(inv_ls),
        .hs_pin(hs_pin), .ls_pin(ls_pin)
    );

    always #4 clk = ~clk;

    // Model advances at each rising edge from the stable inputs
    always @(posedge clk) begin
        bit s;
        s = src_pick ? wave_b : wave_a;
        if (!rst_n) begin
            m_level = 0; m_left = 0; m_hs = 0; m_ls = 0;
        end else if (split_mode) begin
            m_hs = wave_a; m_ls = wave_b; m_level = s; m_left = 0;
        end else begin
            if (s != m_level) begin
                m_level = s;
                m_left = s ? int'(gap_hs) : int'(gap_ls);
            end else if (m_left > 0) begin
                m_left = m_left - 1;
            end
            m_hs = m_level && (m_left == 0);
            m_ls = !m_level && (m_left == 0);
        end
        model_live = 1'b1;
    end

    task automatic check(input string t, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string t, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_live) begin
            check(tag, hs_pin, m_hs ^ inv_hs, "hs_pin vs model");
            check(tag, ls_pin, m_ls ^ inv_ls, "ls_pin vs model");
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Count falling-edge samples until the chosen pin is active
    task automatic measure(input bit high_side, input int exp, input string t);
        int k = 0;
        logic on;
        do begin
            @(negedge clk);
            k++;
            on = high_side ? (hs_pin ^ inv_hs) : (ls_pin ^ inv_ls);
        end while (on !== 1'b1 && k < 300);
        check_int(t, k, exp, high_side ? "samples to hs on" : "samples to ls on");
        #1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R9 and R8: reset shows inactive level per polarity
        inv_hs = 1; inv_ls = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", hs_pin, 1'b1, "hs_pin in reset, active-low");
        check("R9", ls_pin, 1'b1, "ls_pin in reset, active-low");
        #1; inv_hs = 0; inv_ls = 0; #1;
        check("R8", hs_pin, 1'b0, "hs_pin after polarity change");
        check("R9", ls_pin, 1'b0, "ls_pin in reset, active-high");
        step();
        rst_n = 1;

        // R1: independent mode, every raw combination
        tag = "R1";
        split_mode = 1;
        for (int p = 0; p < 4; p++) begin
            wave_a = p[1]; wave_b = p[0];
            @(negedge clk);
            check("R1", hs_pin, p[1], "hs follows wave_a");
            check("R1", ls_pin, p[0], "ls follows wave_b");
            #1;
        end
        wave_a = 0; wave_b = 0;
        idle(2);

        // R5: zero gap, pure complement
        tag = "R5";
        split_mode = 0; src_pick = 0; gap_hs = 0; gap_ls = 0;
        idle(3);
        wave_a = 1;
        measure(1'b1, 1, "R5");
        check("R5", ls_pin, 1'b0, "ls off with hs on");
        wave_a = 0;
        measure(1'b0, 1, "R5");
        check("R5", hs_pin, 1'b0, "hs off with ls on");

        // R2: source selection, non-selected wave ignored
        tag = "R2";
        wave_a = 0; wave_b = 1; src_pick = 1;
        idle(3);
        check("R2", hs_pin, 1'b1, "hs on from wave_b");
        wave_a = 1; wave_b = 0;
        idle(3);
        check("R2", ls_pin, 1'b1, "ls on, wave_a ignored");
        check("R2", hs_pin, 1'b0, "hs off, wave_a ignored");
        src_pick = 0;
        idle(3);
        check("R2", hs_pin, 1'b1, "hs on after select to wave_a");

        // R3 / R4: unequal gaps
        gap_hs = 5; gap_ls = 3;
        wave_a = 0;
        idle(10);
        tag = "R3";
        wave_a = 1;
        measure(1'b1, 6, "R3");
        idle(2);
        tag = "R4";
        wave_a = 0;
        measure(1'b0, 4, "R4");
        idle(2);

        // R6: reversal inside the gap restarts with new-direction count
        tag = "R6";
        wave_a = 1;
        idle(2);
        wave_a = 0;
        measure(1'b0, 4, "R6");
        wave_a = 1;
        idle(1);
        wave_a = 0;
        idle(2);
        wave_a = 1;
        measure(1'b1, 6, "R6");

        // R8: polarity applied combinationally
        tag = "R8";
        inv_hs = 1; #1;
        check("R8", hs_pin, 1'b0, "hs active-low while active");
        check("R8", ls_pin, 1'b0, "ls inactive, active-high");
        inv_ls = 1; #1;
        check("R8", ls_pin, 1'b1, "ls inactive, active-low");
        inv_hs = 0; inv_ls = 0;
        idle(2);

        // R7: randomized mix compared every cycle, interlock checked
        tag = "R7";
        begin
            int calm = 0;
            for (int i = 0; i < 4000; i++) begin
                wave_a = ($urandom_range(0, 3) == 0) ? ~wave_a : wave_a;
                wave_b = ($urandom_range(0, 3) == 0) ? ~wave_b : wave_b;
                if ($urandom_range(0, 60) == 0) src_pick = ~src_pick;
                if ($urandom_range(0, 150) == 0) split_mode = ~split_mode;
                if ($urandom_range(0, 40) == 0) gap_hs = CW'($urandom_range(0, 7));
                if ($urandom_range(0, 40) == 0) gap_ls = CW'($urandom_range(0, 7));
                if ($urandom_range(0, 80) == 0) inv_hs = ~inv_hs;
                if ($urandom_range(0, 80) == 0) inv_ls = ~inv_ls;
                calm = split_mode ? 0 : calm + 1;
                @(negedge clk);
                if (calm >= 2)
                    check("R7", (hs_pin ^ inv_hs) & (ls_pin ^ inv_ls), 1'b0, "both active");
                #1;
            end
        end

        summary();
        $finish;
    end
endmodule